// File: doc/BRIEF.md
# Strap-Configured Pin Mux Controller

This block decides, once per reset, who owns two groups of shared device pins. A 32-bit parallel group is shared between an external memory interface and general-purpose I/O. An 8-bit host group is shared between a multiplexed host port and general-purpose I/O. While reset is held, the block samples a single strap input on every clock. The value taken at the last clock edge of reset becomes the mode for the rest of the run. A high strap gives both pin groups to the two peripherals. A low strap gives both groups to general-purpose I/O and disables the two peripherals.

The mode steers each pad's output value and output enable. It also steers the pad input back to the owner and returns zero to the peripheral that does not own the pads. The memory interface receives its clock enable only while it owns its pins. The peripheral bus is watched for strobes into the address window of a deselected peripheral. When the peripheral-timeout enable is set, such a strobe raises a one-cycle bus error.

A 16-bit configuration word sits at word address 0x6C00 on a small register port. It reports the mode in bit 0 and holds two spare read/write bits at positions 3 and 2. After reset, the mode cannot be changed through this word.

Top module: `pinmux_strap_ctrl`

## Requirements
- R1: The mode equals the strap value present at the last rising clock edge with `rst` high. Strap changes after reset have no effect, and the mode reads back as bit 0 of the configuration word.
- R2: With mode 1, `emif_sel` and `hpi_sel` are 1 and both GPIO selects are 0. Parallel pads carry `emif_do`, with every enable bit equal to `emif_oe`. Host pads carry `hpi_do`, with every enable bit equal to `hpi_oe`. Pad inputs appear on `emif_di` and `hpi_di`, and both GPIO input views are zero.
- R3: With mode 0, both GPIO selects are 1 and both peripheral selects are 0. Each pad carries its GPIO bit value and per-bit enable. Pad inputs appear on the GPIO input views, and `emif_di` and `hpi_di` are zero.
- R4: `emif_clk_en` is 1 exactly when the memory interface is selected.
- R5: A strobe on `acc_stb` into the window of a deselected peripheral, with `tout_en` = 1, makes `bus_err` high for exactly the next cycle. The memory window is address & 0xC00000 == 0x400000. The host window is address & 0xFF0000 == 0x010000.
- R6: `bus_err` stays 0 when `tout_en` is 0, when the address lies outside both windows, or when the addressed peripheral is selected.
- R7: A read strobe at address 0x6C00 returns {12'b0, bit3, bit2, 1'b0, mode} on `reg_rdata` in the next cycle. In every other cycle, including after a read of any other address, `reg_rdata` is zero.
- R8: Bits 3 and 2 reset to zero. A write at 0x6C00 whose bits 15:4 and bit 1 are all zero loads them from write-data bits 3 and 2.
- R9: A write at 0x6C00 with any of bits 15:4 or bit 1 set is discarded entirely. Writes to other addresses change nothing.
- R10: The value written to bit 0 is ignored. The mode, the selects and the pad routing stay as captured at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_i | input | 1 | Mode strap, sampled while in reset |
| reg_cs | input | 1 | Register port strobe |
| reg_we | input | 1 | Register port write (1) or read (0) |
| reg_addr | input | 16 | Register port word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after a read strobe |
| acc_stb | input | 1 | Peripheral bus access strobe |
| acc_addr | input | 24 | Peripheral bus access address |
| tout_en | input | 1 | Peripheral-timeout enable |
| bus_err | output | 1 | Bus error pulse |
| emif_sel | output | 1 | Memory interface owns the parallel group |
| hpi_sel | output | 1 | Host port owns the host group |
| gpio_par_sel | output | 1 | GPIO owns the parallel group |
| gpio_host_sel | output | 1 | GPIO owns the host group |
| emif_clk_en | output | 1 | Memory interface clock enable |
| emif_do | input | 32 | Memory interface output data |
| emif_oe | input | 1 | Memory interface output enable |
| emif_di | output | 32 | Memory interface input view |
| gpio_par_do | input | 32 | Parallel GPIO output data |
| gpio_par_oe | input | 32 | Parallel GPIO per-bit output enable |
| gpio_par_di | output | 32 | Parallel GPIO input view |
| par_pad_i | input | 32 | Parallel pad input values |
| par_pad_o | output | 32 | Parallel pad output values |
| par_pad_oe | output | 32 | Parallel pad output enables |
| hpi_do | input | 8 | Host port output data |
| hpi_oe | input | 1 | Host port output enable |
| hpi_di | output | 8 | Host port input view |
| gpio_host_do | input | 8 | Host GPIO output data |
| gpio_host_oe | input | 8 | Host GPIO per-bit output enable |
| gpio_host_di | output | 8 | Host GPIO input view |
| host_pad_i | input | 8 | Host pad input values |
| host_pad_o | output | 8 | Host pad output values |
| host_pad_oe | output | 8 | Host pad output enables |

## Verification
A register write that tries to flip the mode bit can land in the same clock as a bus strobe into the deselected memory window. The bench provokes this with the strap low. In a single cycle it drives a write of 0x000D to 0x6C00 and a strobe at a memory-window address with the timeout enable set. The result is judged in three places. The bus error must still pulse in the next cycle. The spare bits must read back as written, while bit 0 stays zero. The memory interface select and clock enable must stay low.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int REG_W = 16;

  // Address window match: compare only the bits kept by the mask.
  function automatic logic in_window(logic [31:0] addr, logic [31:0] base,
                                     logic [31:0] mask);
    return (addr & mask) == (base & mask);
  endfunction

  // Read image of the configuration word.
  function automatic logic [REG_W-1:0] cfg_image(logic mode, logic [1:0] spare);
    return {12'h000, spare, 1'b0, mode};
  endfunction

  // True when a write touches any read-only position (15:4 or 1).
  function automatic logic ro_bits_set(logic [REG_W-1:0] wd);
    return (|wd[REG_W-1:4]) | wd[1];
  endfunction
endpackage

// File: rtl/pm_cfg_reg.sv
module pm_cfg_reg
  import pinmux_pkg::*;
#(
  parameter logic [15:0] REG_ADDR = 16'h6C00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_i,
  input  logic             reg_cs,
  input  logic             reg_we,
  input  logic [15:0]      reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mode_o,
  output logic             mode_wr_attempt_o
);
  logic       addr_hit;
  logic       wr_hit;
  logic       rd_hit;
  logic       wr_accept;
  logic       mode_q;
  logic [1:0] spare_q;

  assign addr_hit  = reg_cs && (reg_addr == REG_ADDR);
  assign wr_hit    = addr_hit && reg_we;
  assign rd_hit    = addr_hit && !reg_we;
  assign wr_accept = wr_hit && !ro_bits_set(reg_wdata);
  // A write that would change the mode if it were honoured.
  assign mode_wr_attempt_o = wr_accept && (reg_wdata[0] != mode_q);

  // The strap is followed while in reset; the last reset edge fixes it.
  always_ff @(posedge clk) begin
    if (rst) mode_q <= strap_i;
  end

  always_ff @(posedge clk) begin
    if (rst)            spare_q <= 2'b00;
    else if (wr_accept) spare_q <= reg_wdata[3:2];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (rd_hit) reg_rdata <= cfg_image(mode_q, spare_q);
    else             reg_rdata <= '0;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pm_pad_mux.sv
module pm_pad_mux #(
  parameter int W = 32
) (
  input  logic         sel_a,
  input  logic [W-1:0] a_do,
  input  logic [W-1:0] a_oe,
  input  logic [W-1:0] b_do,
  input  logic [W-1:0] b_oe,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] a_di,
  output logic [W-1:0] b_di
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pad_o[i]  = sel_a ? a_do[i] : b_do[i];
    assign pad_oe[i] = sel_a ? a_oe[i] : b_oe[i];
    assign a_di[i]   = sel_a & pad_i[i];
    assign b_di[i]   = !sel_a & pad_i[i];
  end
endmodule

// File: rtl/pm_acc_guard.sv
module pm_acc_guard
  import pinmux_pkg::*;
#(
  parameter int          AW        = 24,
  parameter logic [31:0] EMIF_BASE = 32'h0040_0000,
  parameter logic [31:0] EMIF_MASK = 32'h00C0_0000,
  parameter logic [31:0] HPI_BASE  = 32'h0001_0000,
  parameter logic [31:0] HPI_MASK  = 32'h00FF_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_stb,
  input  logic [AW-1:0] acc_addr,
  input  logic          tout_en,
  input  logic          emif_sel,
  input  logic          hpi_sel,
  output logic          emif_miss,
  output logic          hpi_miss,
  output logic          bus_err
);
  logic [31:0] addr_ext;
  assign addr_ext = 32'(acc_addr);

  assign emif_miss = acc_stb && !emif_sel && in_window(addr_ext, EMIF_BASE, EMIF_MASK);
  assign hpi_miss  = acc_stb && !hpi_sel  && in_window(addr_ext, HPI_BASE, HPI_MASK);

  always_ff @(posedge clk) begin
    if (rst) bus_err <= 1'b0;
    else     bus_err <= tout_en && (emif_miss || hpi_miss);
  end
endmodule

// File: rtl/pinmux_strap_ctrl.sv
module pinmux_strap_ctrl
  import pinmux_pkg::*;
#(
  parameter int          PAR_W     = 32,
  parameter int          HOST_W    = 8,
  parameter int          ACC_AW    = 24,
  parameter logic [15:0] REG_ADDR  = 16'h6C00,
  parameter logic [31:0] EMIF_BASE = 32'h0040_0000,
  parameter logic [31:0] EMIF_MASK = 32'h00C0_0000,
  parameter logic [31:0] HPI_BASE  = 32'h0001_0000,
  parameter logic [31:0] HPI_MASK  = 32'h00FF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_i,
  input  logic              reg_cs,
  input  logic              reg_we,
  input  logic [15:0]       reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              acc_stb,
  input  logic [ACC_AW-1:0] acc_addr,
  input  logic              tout_en,
  output logic              bus_err,
  output logic              emif_sel,
  output logic              hpi_sel,
  output logic              gpio_par_sel,
  output logic              gpio_host_sel,
  output logic              emif_clk_en,
  input  logic [PAR_W-1:0]  emif_do,
  input  logic              emif_oe,
  output logic [PAR_W-1:0]  emif_di,
  input  logic [PAR_W-1:0]  gpio_par_do,
  input  logic [PAR_W-1:0]  gpio_par_oe,
  output logic [PAR_W-1:0]  gpio_par_di,
  input  logic [PAR_W-1:0]  par_pad_i,
  output logic [PAR_W-1:0]  par_pad_o,
  output logic [PAR_W-1:0]  par_pad_oe,
  input  logic [HOST_W-1:0] hpi_do,
  input  logic              hpi_oe,
  output logic [HOST_W-1:0] hpi_di,
  input  logic [HOST_W-1:0] gpio_host_do,
  input  logic [HOST_W-1:0] gpio_host_oe,
  output logic [HOST_W-1:0] gpio_host_di,
  input  logic [HOST_W-1:0] host_pad_i,
  output logic [HOST_W-1:0] host_pad_o,
  output logic [HOST_W-1:0] host_pad_oe
);
  logic mode;
  logic mode_wr_attempt;
  logic emif_miss;
  logic hpi_miss;

  pm_cfg_reg #(.REG_ADDR(REG_ADDR)) u_cfg (
    .clk               (clk),
    .rst               (rst),
    .strap_i           (strap_i),
    .reg_cs            (reg_cs),
    .reg_we            (reg_we),
    .reg_addr          (reg_addr),
    .reg_wdata         (reg_wdata),
    .reg_rdata         (reg_rdata),
    .mode_o            (mode),
    .mode_wr_attempt_o (mode_wr_attempt)
  );

  assign emif_sel      = mode;
  assign hpi_sel       = mode;
  assign gpio_par_sel  = !mode;
  assign gpio_host_sel = !mode;
  assign emif_clk_en   = emif_sel;

  pm_pad_mux #(.W(PAR_W)) u_par_mux (
    .sel_a  (emif_sel),
    .a_do   (emif_do),
    .a_oe   ({PAR_W{emif_oe}}),
    .b_do   (gpio_par_do),
    .b_oe   (gpio_par_oe),
    .pad_i  (par_pad_i),
    .pad_o  (par_pad_o),
    .pad_oe (par_pad_oe),
    .a_di   (emif_di),
    .b_di   (gpio_par_di)
  );

  pm_pad_mux #(.W(HOST_W)) u_host_mux (
    .sel_a  (hpi_sel),
    .a_do   (hpi_do),
    .a_oe   ({HOST_W{hpi_oe}}),
    .b_do   (gpio_host_do),
    .b_oe   (gpio_host_oe),
    .pad_i  (host_pad_i),
    .pad_o  (host_pad_o),
    .pad_oe (host_pad_oe),
    .a_di   (hpi_di),
    .b_di   (gpio_host_di)
  );

  pm_acc_guard #(
    .AW(ACC_AW), .EMIF_BASE(EMIF_BASE), .EMIF_MASK(EMIF_MASK),
    .HPI_BASE(HPI_BASE), .HPI_MASK(HPI_MASK)
  ) u_guard (
    .clk       (clk),
    .rst       (rst),
    .acc_stb   (acc_stb),
    .acc_addr  (acc_addr),
    .tout_en   (tout_en),
    .emif_sel  (emif_sel),
    .hpi_sel   (hpi_sel),
    .emif_miss (emif_miss),
    .hpi_miss  (hpi_miss),
    .bus_err   (bus_err)
  );
endmodule

// File: rtl/pinmux_strap_chk.sv
module pinmux_strap_chk #(
  parameter int PAR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             emif_sel,
  input logic             gpio_par_sel,
  input logic             emif_clk_en,
  input logic             acc_stb,
  input logic             tout_en,
  input logic             emif_miss,
  input logic             hpi_miss,
  input logic             bus_err,
  input logic [15:0]      reg_rdata,
  input logic             mode_wr_attempt,
  input logic [PAR_W-1:0] par_pad_o,
  input logic [PAR_W-1:0] emif_do
);
  // R4
  clk_en_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !emif_sel |-> !emif_clk_en);

  // R5
  err_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(acc_stb && tout_en));

  // R6
  err_needs_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && !emif_miss && !hpi_miss) |=> !bus_err);

  // R7
  rdata_ro_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[15:4] == 12'h000) && !reg_rdata[1]);

  // R10
  mode_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr_attempt |=> $stable(emif_sel));

  // R3
  group_owner_excl_chk: assert property (@(posedge clk) disable iff (rst)
    emif_sel != gpio_par_sel);

  // R2
  par_route_chk: assert property (@(posedge clk) disable iff (rst)
    emif_sel |-> (par_pad_o == emif_do));
endmodule

bind pinmux_strap_ctrl pinmux_strap_chk #(.PAR_W(PAR_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .emif_sel        (emif_sel),
  .gpio_par_sel    (gpio_par_sel),
  .emif_clk_en     (emif_clk_en),
  .acc_stb         (acc_stb),
  .tout_en         (tout_en),
  .emif_miss       (emif_miss),
  .hpi_miss        (hpi_miss),
  .bus_err         (bus_err),
  .reg_rdata       (reg_rdata),
  .mode_wr_attempt (mode_wr_attempt),
  .par_pad_o       (par_pad_o),
  .emif_do         (emif_do)
);

// File: tb/pinmux_strap_ctrl_test.sv
module pinmux_strap_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_i = 1'b0;
  logic        reg_cs = 1'b0, reg_we = 1'b0;
  logic [15:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic        acc_stb = 1'b0, tout_en = 1'b0, bus_err;
  logic [23:0] acc_addr = '0;
  logic        emif_sel, hpi_sel, gpio_par_sel, gpio_host_sel, emif_clk_en;
  logic [31:0] emif_do = '0, emif_di, gpio_par_do = '0, gpio_par_oe = '0, gpio_par_di;
  logic [31:0] par_pad_i = '0, par_pad_o, par_pad_oe;
  logic        emif_oe = 1'b0, hpi_oe = 1'b0;
  logic [7:0]  hpi_do = '0, hpi_di, gpio_host_do = '0, gpio_host_oe = '0, gpio_host_di;
  logic [7:0]  host_pad_i = '0, host_pad_o, host_pad_oe;

  int tests = 0;
  int fails = 0;
  logic [15:0] rd;

  localparam logic [23:0] A_EMIF = 24'h412345;
  localparam logic [23:0] A_HPI  = 24'h01ABCD;
  localparam logic [23:0] A_NONE = 24'h200000;

  always #4 clk = !clk;

  pinmux_strap_ctrl uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst = 1'b1;
    strap_i = !s;
    repeat (2) @(negedge clk);
    strap_i = s;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_cs = 1'b0;
    v = reg_rdata;
  endtask

  task automatic access(input string req, input logic [23:0] a, input logic te,
                        input logic exp);
    @(negedge clk);
    acc_stb = 1'b1; acc_addr = a; tout_en = te;
    @(negedge clk);
    acc_stb = 1'b0;
    check(req, bus_err, exp);
    @(negedge clk);
    check({req, " pulse end"}, bus_err, 1'b0);
  endtask

  task automatic t_strap_high_capture;
    do_reset(1'b1);
    check("R1 mode captured high", emif_sel, 1'b1);
    check("R7 idle rdata zero", reg_rdata, 16'h0000);
    check("R5 no error after reset", bus_err, 1'b0);
    strap_i = 1'b0;
    @(negedge clk);
    check("R1 strap change ignored", emif_sel, 1'b1);
    reg_read(16'h6C00, rd);
    check("R1 R7 read mode 1", rd, 16'h0001);
    @(negedge clk);
    check("R7 rdata back to zero", reg_rdata, 16'h0000);
  endtask

  task automatic t_route_peripherals;
    emif_do = 32'hA5A5_0F0F; emif_oe = 1'b1; gpio_par_do = 32'h1234_5678;
    gpio_par_oe = 32'h0000_FFFF; par_pad_i = 32'hDEAD_BEEF;
    hpi_do = 8'h3C; hpi_oe = 1'b0; gpio_host_do = 8'hC3; gpio_host_oe = 8'hFF;
    host_pad_i = 8'h96;
    #1;
    check("R2 hpi_sel", hpi_sel, 1'b1);
    check("R2 gpio selects", {gpio_par_sel, gpio_host_sel}, 2'b00);
    check("R2 par pad data", par_pad_o, 32'hA5A5_0F0F);
    check("R2 par pad oe", par_pad_oe, 32'hFFFF_FFFF);
    check("R2 host pad data", host_pad_o, 8'h3C);
    check("R2 host pad oe", host_pad_oe, 8'h00);
    check("R2 emif input view", emif_di, 32'hDEAD_BEEF);
    check("R2 hpi input view", hpi_di, 8'h96);
    check("R2 gpio input views zero", {gpio_par_di, gpio_host_di}, 40'h0);
    check("R4 clock enable on", emif_clk_en, 1'b1);
  endtask

  task automatic t_selected_access;
    access("R6 emif window selected", A_EMIF, 1'b1, 1'b0);
    access("R6 hpi window selected", A_HPI, 1'b1, 1'b0);
  endtask

  task automatic t_spare_bits;
    reg_write(16'h6C00, 16'h000C);
    reg_read(16'h6C00, rd);
    check("R8 spare bits written", rd, 16'h000D);
    reg_write(16'h6C00, 16'h0010);
    reg_read(16'h6C00, rd);
    check("R9 high ro bit discards write", rd, 16'h000D);
    reg_write(16'h6C00, 16'h0002);
    reg_read(16'h6C00, rd);
    check("R9 bit1 discards write", rd, 16'h000D);
    reg_write(16'h6C01, 16'h0000);
    reg_read(16'h6C00, rd);
    check("R9 other address ignored", rd, 16'h000D);
    reg_write(16'h6C00, 16'h0000);
    reg_read(16'h6C00, rd);
    check("R10 bit0 write ignored, spares cleared", rd, 16'h0001);
    check("R10 routing kept", {emif_sel, par_pad_o}, {1'b1, 32'hA5A5_0F0F});
  endtask

  task automatic t_strap_low_route;
    do_reset(1'b0);
    reg_read(16'h6C00, rd);
    check("R8 R1 reset image strap low", rd, 16'h0000);
    #1;
    check("R3 selects", {emif_sel, hpi_sel, gpio_par_sel, gpio_host_sel}, 4'b0011);
    check("R3 par pads", {par_pad_o, par_pad_oe}, {32'h1234_5678, 32'h0000_FFFF});
    check("R3 host pads", {host_pad_o, host_pad_oe}, {8'hC3, 8'hFF});
    check("R3 gpio input views", {gpio_par_di, gpio_host_di}, {32'hDEAD_BEEF, 8'h96});
    check("R3 peripheral views zero", {emif_di, hpi_di}, 40'h0);
    check("R4 clock enable off", emif_clk_en, 1'b0);
  endtask

  task automatic t_bus_errors;
    access("R5 emif window deselected", A_EMIF, 1'b1, 1'b1);
    access("R5 hpi window deselected", A_HPI, 1'b1, 1'b1);
    access("R6 timeout disabled", A_EMIF, 1'b0, 1'b0);
    access("R6 outside windows", A_NONE, 1'b1, 1'b0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = 16'h6C00; reg_wdata = 16'h000D;
    acc_stb = 1'b1; acc_addr = A_EMIF; tout_en = 1'b1;
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0; acc_stb = 1'b0;
    check("R5 error with concurrent write", bus_err, 1'b1);
    check("R10 mode still low", {emif_sel, emif_clk_en}, 2'b00);
    reg_read(16'h6C00, rd);
    check("R10 R8 read after concurrent write", rd, 16'h000C);
    reg_read(16'h6C02, rd);
    check("R7 other address reads zero", rd, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_strap_high_capture();
    t_route_peripherals();
    t_selected_access();
    t_spare_bits();
    t_strap_low_route();
    t_bus_errors();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule